// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel NOR flash. It watches bus write cycles, each one presented as a single-cycle write-valid pulse that carries both the address and the data byte. It recognises the multi-write command sequences that begin with a fixed two-write unlock, and the few commands that need only one write. When a sequence completes it raises a one-cycle operation strobe for the embedded algorithm, the mode logic or the read path, together with the address and data of the final write.

The decoder keeps the device mode: array read, identifier (autoselect) read or query (CFI) read. It also keeps two flags. One says that a sector erase is active and can be suspended. The other says that an erase is suspended. A third flag marks that the secure sector region is mapped in. Several commands are accepted only in certain modes, so this state carries over from one sequence to the next. A read-source select tells the read multiplexer whether to return array data, identifier codes, query data or algorithm status. An external algorithm model supplies a busy level and a done pulse.

Top module: `flash_cmd_decoder`

## Requirements
- R1: An unlocked sequence starts with AAh written to an address whose low 12 bits are AAAh, followed by 55h to low bits 555h. Address bits above bit 11 are ignored. An unlock is started only in array mode (0), suspended or not.
- R2: After the unlock, A0h at AAAh and then one write of any data to any address raises the program strobe (bit 3), with op_addr_o/op_data_o equal to that final write. The data F0h is programmed like any other value in that cycle.
- R3: After the unlock, the writes 80h@AAAh, AAh@AAAh, 55h@555h, then 10h@AAAh raise the chip-erase strobe (bit 4). If the last of these writes is instead 30h to any address, the sector-erase strobe (bit 5) is raised with that address.
- R4: After the unlock, 90h at AAAh raises the autoselect strobe (bit 1), sets mode_o to 1 and sets rd_sel_o to 1 (identifier).
- R5: A single 98h written to low address bits 0AAh raises the query strobe (bit 2) and sets mode_o to 2 and rd_sel_o to 2. It is accepted only in autoselect mode, or in array mode with no erase suspended; in every other state it does nothing.
- R6: F0h written to any address raises the reset strobe (bit 0) and returns mode_o to 0, whatever sequence is in progress, except in the program data cycle. susp_o is left unchanged.
- R7: A write that does not match the next step of the current sequence (F0h excepted) returns the decoder to idle with no strobe. The write that follows is then decoded from idle.
- R8: While alg_busy_i is high, every write is ignored except B0h, which suspends an active sector erase.
- R9: B0h (bit 6) is accepted only while a sector erase is active. Such an erase runs from the sector-erase strobe until an alg_done_i pulse, and the suspend sets susp_o. 30h at idle (bit 7) is accepted only while susp_o is 1; it clears susp_o and makes the erase active again. An erase sequence is aborted at its 80h step while suspended.
- R10: After the unlock, 88h at AAAh raises secure-entry (bit 8) and sets secure_o. While secure_o is 1, the unlock followed by 90h@AAAh and then 00h to any address raises secure-exit (bit 9) and clears secure_o.
- R11: Strobes appear in the clock cycle after the accepted write, last one cycle, and at most one bit is set at a time.
- R12: rd_sel_o is 3 (status) while alg_busy_i is high. Otherwise it follows mode_o: 0 array, 1 identifier, 2 query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid_i | input | 1 | One-cycle bus write pulse |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data byte |
| alg_busy_i | input | 1 | Embedded algorithm running |
| alg_done_i | input | 1 | Pulse when an algorithm finishes |
| op_strobe_o | output | 10 | One-hot operation strobes (bit map in R2–R10) |
| op_addr_o | output | ADDR_W | Address of the write that completed the command |
| op_data_o | output | 8 | Data of the write that completed the command |
| mode_o | output | 2 | 0 array, 1 autoselect, 2 query |
| susp_o | output | 1 | Erase suspended |
| secure_o | output | 1 | Secure region mapped in |
| rd_sel_o | output | 2 | Read source: 0 array, 1 identifier, 2 query, 3 status |

## Verification
On every cycle the assertions check these properties: strobes are one-hot and follow an accepted write, only a suspend can come out of a busy cycle, suspend and resume are only issued from the right erase state, a query strobe arrives together with query mode, and a completed command leaves the sequencer idle. Only the directed scenarios can show the rest: that whole sequences decode to the right strobe with the right address and data, that upper address bits are ignored, that mismatches abort silently, that F0h is programmed as data in the program data cycle, and that mode and read-select transitions cover suspend, resume, identifier and secure-region round trips.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;
    localparam int OP_N  = 10;
    localparam int CMP_W = 12;

    localparam logic [CMP_W-1:0] ADR_AAA = 12'hAAA;
    localparam logic [CMP_W-1:0] ADR_555 = 12'h555;
    localparam logic [CMP_W-1:0] ADR_QRY = 12'h0AA;

    localparam logic [7:0] D_UNLA  = 8'hAA;
    localparam logic [7:0] D_UNLB  = 8'h55;
    localparam logic [7:0] D_IDENT = 8'h90;
    localparam logic [7:0] D_SECIN = 8'h88;
    localparam logic [7:0] D_PROG  = 8'hA0;
    localparam logic [7:0] D_ERASE = 8'h80;
    localparam logic [7:0] D_CHIP  = 8'h10;
    localparam logic [7:0] D_SECT  = 8'h30;
    localparam logic [7:0] D_SUSP  = 8'hB0;
    localparam logic [7:0] D_QRY   = 8'h98;
    localparam logic [7:0] D_RST   = 8'hF0;
    localparam logic [7:0] D_EXIT  = 8'h00;

    typedef enum logic [3:0] {
        CMD_NONE, CMD_RESET, CMD_AUTOSEL, CMD_CFI, CMD_PROG, CMD_CHIP,
        CMD_SECT, CMD_SUSP, CMD_RES, CMD_SEC_IN, CMD_SEC_OUT
    } cmd_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PDATA, SQ_ER1, SQ_ER2, SQ_ER3, SQ_EXIT
    } seq_e;

    typedef enum logic [1:0] {MD_ARRAY = 2'd0, MD_AUTOSEL = 2'd1, MD_CFI = 2'd2} mode_e;
    typedef enum logic [1:0] {RS_ARRAY, RS_ID, RS_CFI, RS_STATUS} rdsel_e;

    typedef struct packed {
        mode_e mode;
        logic  susp;
        logic  erase_act;
        logic  secure;
    } flags_t;

    function automatic logic [OP_N-1:0] cmd_onehot(input cmd_e c);
        logic [OP_N-1:0] v;
        v = '0;
        if (c != CMD_NONE) v[int'(c) - 1] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/flcmd_seq.sv
module flcmd_seq
    import flcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [CMP_W-1:0] addr_lo,
    input  logic [7:0]       data,
    input  logic             busy,
    input  flags_t           st,
    output cmd_e             cmd
);
    seq_e state, state_nx;
    logic accept, at_aaa, at_555;

    assign at_aaa = (addr_lo == ADR_AAA);
    assign at_555 = (addr_lo == ADR_555);
    assign accept = wr_valid && (!busy || (data == D_SUSP && st.erase_act && !st.susp));

    always_comb begin
        state_nx = state;
        cmd      = CMD_NONE;
        if (accept) begin
            state_nx = SQ_IDLE;
            if (state != SQ_PDATA && data == D_RST) begin
                cmd = CMD_RESET;
            end else begin
                unique case (state)
                    SQ_IDLE: begin
                        if (data == D_SUSP && st.erase_act && !st.susp)
                            cmd = CMD_SUSP;
                        else if (data == D_SECT && st.susp)
                            cmd = CMD_RES;
                        else if (data == D_QRY && addr_lo == ADR_QRY &&
                                 (st.mode == MD_AUTOSEL || (st.mode == MD_ARRAY && !st.susp)))
                            cmd = CMD_CFI;
                        else if (data == D_UNLA && at_aaa && st.mode == MD_ARRAY)
                            state_nx = SQ_UNL1;
                    end
                    SQ_UNL1: if (data == D_UNLB && at_555) state_nx = SQ_UNL2;
                    SQ_UNL2: if (at_aaa) begin
                        if (data == D_IDENT) begin
                            if (st.secure) state_nx = SQ_EXIT;
                            else           cmd = CMD_AUTOSEL;
                        end
                        else if (data == D_SECIN)              cmd = CMD_SEC_IN;
                        else if (data == D_PROG)               state_nx = SQ_PDATA;
                        else if (data == D_ERASE && !st.susp)  state_nx = SQ_ER1;
                    end
                    SQ_PDATA: cmd = CMD_PROG;
                    SQ_ER1:   if (data == D_UNLA && at_aaa) state_nx = SQ_ER2;
                    SQ_ER2:   if (data == D_UNLB && at_555) state_nx = SQ_ER3;
                    SQ_ER3: begin
                        if (data == D_CHIP && at_aaa) cmd = CMD_CHIP;
                        else if (data == D_SECT)      cmd = CMD_SECT;
                    end
                    SQ_EXIT:  if (data == D_EXIT) cmd = CMD_SEC_OUT;
                    default:  state_nx = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SQ_IDLE;
        else     state <= state_nx;
    end

    // R7
    done_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NONE) |=> (state == SQ_IDLE));
endmodule

// File: rtl/flcmd_mode.sv
module flcmd_mode
    import flcmd_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    input  logic              done,
    output flags_t            st,
    output logic [OP_N-1:0]   strobe,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '{mode: MD_ARRAY, susp: 1'b0, erase_act: 1'b0, secure: 1'b0};
            strobe  <= '0;
            op_addr <= '0;
            op_data <= '0;
        end else begin
            strobe <= cmd_onehot(cmd);
            if (cmd != CMD_NONE) begin
                op_addr <= addr;
                op_data <= data;
            end
            if (done) st.erase_act <= 1'b0;
            case (cmd)
                CMD_RESET:   st.mode <= MD_ARRAY;
                CMD_AUTOSEL: st.mode <= MD_AUTOSEL;
                CMD_CFI:     st.mode <= MD_CFI;
                CMD_SECT:    st.erase_act <= 1'b1;
                CMD_SUSP:    begin st.erase_act <= 1'b0; st.susp <= 1'b1; end
                CMD_RES:     begin st.erase_act <= 1'b1; st.susp <= 1'b0; st.mode <= MD_ARRAY; end
                CMD_SEC_IN:  st.secure <= 1'b1;
                CMD_SEC_OUT: st.secure <= 1'b0;
                default: ;
            endcase
        end
    end

    // R9
    suspend_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_SUSP) |-> (st.erase_act && !st.susp));
    // R9
    resume_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RES) |-> st.susp);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flcmd_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic              alg_busy_i,
    input  logic              alg_done_i,
    output logic [9:0]        op_strobe_o,
    output logic [ADDR_W-1:0] op_addr_o,
    output logic [7:0]        op_data_o,
    output logic [1:0]        mode_o,
    output logic              susp_o,
    output logic              secure_o,
    output logic [1:0]        rd_sel_o
);
    flags_t st;
    cmd_e   cmd;
    rdsel_e rsel;

    flcmd_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid_i),
        .addr_lo  (wr_addr_i[CMP_W-1:0]),
        .data     (wr_data_i),
        .busy     (alg_busy_i),
        .st       (st),
        .cmd      (cmd)
    );

    flcmd_mode #(.ADDR_W(ADDR_W)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .addr    (wr_addr_i),
        .data    (wr_data_i),
        .done    (alg_done_i),
        .st      (st),
        .strobe  (op_strobe_o),
        .op_addr (op_addr_o),
        .op_data (op_data_o)
    );

    always_comb begin
        if (alg_busy_i)               rsel = RS_STATUS;
        else if (st.mode == MD_AUTOSEL) rsel = RS_ID;
        else if (st.mode == MD_CFI)     rsel = RS_CFI;
        else                            rsel = RS_ARRAY;
    end

    assign rd_sel_o = rsel;
    assign mode_o   = st.mode;
    assign susp_o   = st.susp;
    assign secure_o = st.secure;

    // R11
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(op_strobe_o));
    // R11
    strobe_from_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op_strobe_o != '0) |-> $past(wr_valid_i));
    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(alg_busy_i) && op_strobe_o != '0) |-> (op_strobe_o == 10'b00_0100_0000));
    // R5
    cfi_mode_chk: assert property (@(posedge clk) disable iff (rst)
        op_strobe_o[2] |-> (mode_o == 2'd2));
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
    localparam int AW = 22;
    localparam logic [9:0] S_RST = 10'd1 << 0, S_ID = 10'd1 << 1, S_QRY = 10'd1 << 2,
        S_PRG = 10'd1 << 3, S_CHP = 10'd1 << 4, S_SEC = 10'd1 << 5, S_SUS = 10'd1 << 6,
        S_RES = 10'd1 << 7, S_SIN = 10'd1 << 8, S_SOUT = 10'd1 << 9;

    logic clk = 1'b0, rst = 1'b1;
    logic wr_valid = 1'b0, busy = 1'b0, done = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] data = '0;
    logic [9:0] strobe;
    logic [AW-1:0] op_addr;
    logic [7:0] op_data;
    logic [1:0] mode, rd_sel;
    logic susp, secure;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW)) u_flash_cmd_decoder (
        .clk(clk), .rst(rst), .wr_valid_i(wr_valid), .wr_addr_i(addr), .wr_data_i(data),
        .alg_busy_i(busy), .alg_done_i(done), .op_strobe_o(strobe), .op_addr_o(op_addr),
        .op_data_o(op_data), .mode_o(mode), .susp_o(susp), .secure_o(secure), .rd_sel_o(rd_sel));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, output logic [9:0] s);
        @(negedge clk);
        wr_valid = 1'b1; addr = a; data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        s = strobe;
    endtask

    task automatic unlock(input string req);
        logic [9:0] s;
        wr(22'h000AAA, 8'hAA, s); check(req, s, 0);
        wr(22'h000555, 8'h55, s); check(req, s, 0);
    endtask

    task automatic t_reset_state();
        check("R11 reset strobe", strobe, 0);
        check("R12 reset mode", mode, 0);
        check("R12 reset rdsel", rd_sel, 0);
        check("R9 reset susp", susp, 0);
        check("R10 reset secure", secure, 0);
    endtask

    task automatic t_program();
        logic [9:0] s;
        // R1: upper address bits set on unlock writes
        wr(22'h3FFAAA, 8'hAA, s); check("R1 hi bits", s, 0);
        wr(22'h2A5555, 8'h55, s); check("R1 hi bits", s, 0);
        wr(22'h155AAA, 8'hA0, s); check("R2 cmd", s, 0);
        wr(22'h0ABCDE, 8'h5A, s);
        check("R2 strobe", s, S_PRG);
        check("R2 addr", op_addr, 22'h0ABCDE);
        check("R2 data", op_data, 8'h5A);
        @(negedge clk); check("R11 one cycle", strobe, 0);
        // R2: F0 as program data
        unlock("R2");
        wr(22'h000AAA, 8'hA0, s);
        wr(22'h000123, 8'hF0, s);
        check("R2 F0 data", s, S_PRG);
        check("R2 F0 data val", op_data, 8'hF0);
    endtask

    task automatic t_ident_query();
        logic [9:0] s;
        unlock("R4");
        wr(22'h000AAA, 8'h90, s);
        check("R4 strobe", s, S_ID);
        check("R4 mode", mode, 1);
        check("R12 id sel", rd_sel, 1);
        wr(22'h0000AA, 8'h98, s);
        check("R5 from autosel", s, S_QRY);
        check("R5 mode", mode, 2);
        check("R12 cfi sel", rd_sel, 2);
        wr(22'h000AAA, 8'hAA, s);
        check("R1 no unlock in query", s, 0);
        wr(22'h000555, 8'hF0, s);
        check("R6 strobe", s, S_RST);
        check("R6 mode", mode, 0);
        wr(22'h3000AA, 8'h98, s);
        check("R5 from array", s, S_QRY);
        wr(22'h000000, 8'hF0, s);
        check("R6 back", mode, 0);
    endtask

    task automatic t_abort();
        logic [9:0] s;
        wr(22'h000AAA, 8'hAA, s);
        wr(22'h000554, 8'h55, s); check("R7 bad addr", s, 0);
        wr(22'h000AAA, 8'hA0, s); check("R7 idle after abort", s, 0);
        wr(22'h000100, 8'h12, s); check("R7 no program", s, 0);
        wr(22'h000AAA, 8'hAA, s);
        wr(22'h000777, 8'hF0, s); check("R6 mid sequence", s, S_RST);
        unlock("R7");
        wr(22'h000AAA, 8'h80, s);
        wr(22'h000AAA, 8'hAA, s);
        wr(22'h000555, 8'h55, s);
        wr(22'h000ABC, 8'h10, s); check("R7 chip wrong addr", s, 0);
    endtask

    task automatic t_erase_suspend();
        logic [9:0] s;
        wr(22'h000000, 8'hB0, s); check("R9 suspend idle", s, 0);
        wr(22'h000000, 8'h30, s); check("R9 resume idle", s, 0);
        unlock("R3");
        wr(22'h000AAA, 8'h80, s);
        wr(22'h000AAA, 8'hAA, s);
        wr(22'h000555, 8'h55, s);
        wr(22'h000AAA, 8'h10, s); check("R3 chip", s, S_CHP);
        unlock("R3");
        wr(22'h000AAA, 8'h80, s);
        wr(22'h000AAA, 8'hAA, s);
        wr(22'h000555, 8'h55, s);
        wr(22'h1A0000, 8'h30, s);
        check("R3 sector", s, S_SEC);
        check("R3 sector addr", op_addr, 22'h1A0000);
        @(negedge clk); busy = 1'b1;
        #1 check("R12 status", rd_sel, 3);
        wr(22'h000AAA, 8'hAA, s); check("R8 busy ignore", s, 0);
        wr(22'h000555, 8'h55, s); check("R8 busy ignore", s, 0);
        wr(22'h000000, 8'hF0, s); check("R8 busy F0", s, 0);
        wr(22'h012345, 8'hB0, s);
        check("R9 suspend", s, S_SUS);
        check("R9 susp flag", susp, 1);
        @(negedge clk); busy = 1'b0;
        #1 check("R12 susp array", rd_sel, 0);
        unlock("R9");
        wr(22'h000AAA, 8'h80, s); check("R9 erase in susp", s, 0);
        wr(22'h000AAA, 8'hAA, s);
        wr(22'h000555, 8'h55, s);
        wr(22'h000AAA, 8'h10, s); check("R9 erase aborted", s, 0);
        wr(22'h0000AA, 8'h98, s); check("R5 reject in susp", s, 0);
        check("R5 mode kept", mode, 0);
        unlock("R4");
        wr(22'h000AAA, 8'h90, s); check("R4 in susp", s, S_ID);
        wr(22'h000000, 8'hF0, s);
        check("R6 reset in susp", s, S_RST);
        check("R6 susp kept", susp, 1);
        check("R6 mode", mode, 0);
        wr(22'h000000, 8'h30, s);
        check("R9 resume", s, S_RES);
        check("R9 susp clear", susp, 0);
        @(negedge clk); done = 1'b1;
        @(negedge clk); done = 1'b0;
        wr(22'h000000, 8'hB0, s); check("R9 no suspend after done", s, 0);
    endtask

    task automatic t_secure();
        logic [9:0] s;
        unlock("R10");
        wr(22'h000AAA, 8'h88, s);
        check("R10 enter", s, S_SIN);
        check("R10 flag", secure, 1);
        unlock("R10");
        wr(22'h000AAA, 8'h90, s); check("R10 no autosel", s, 0);
        check("R10 mode", mode, 0);
        wr(22'h0F0F0F, 8'h00, s);
        check("R10 exit", s, S_SOUT);
        check("R10 flag clear", secure, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_program();
        t_ident_query();
        t_abort();
        t_erase_suspend();
        t_secure();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule